// File: doc/BRIEF.md
# Burst Word Parity and Longitudinal Check Unit

This unit sits on the receive side of a word-wide parallel link. Every received 32-bit word comes with four byte parity bits. The unit checks each word on its own for parity faults and forwards the word and its parity bits without change, even when the parity is wrong. It raises a flag for a bad word and takes no other action. Words are grouped into bursts. The sender marks the final data word of a burst. The next accepted word is a longitudinal redundancy word, which summarises the whole burst.

While a burst is in progress, the unit counts its data words and folds each one into an XOR accumulator. That accumulator is seeded with the word count, not with zero. When the redundancy word arrives, the unit compares it with the computed value. The redundancy word is forwarded like any other word, together with a marker and a mismatch flag. The parity flag reaches the output one cycle after the word it describes, which gives a fixed and documented skew.

Top module: `burst_integrity_chk`

## Requirements
- R1: A word accepted with `in_valid` high is driven on `out_data`/`out_par` exactly one clock later, with `out_valid` high in that cycle. `out_valid` is low one clock after any cycle in which `in_valid` is low.
- R2: A word with wrong parity is still forwarded with its data and parity bits unchanged.
- R3: Parity is odd per byte. Bit i of `in_par` covers data bits 8i+7..8i, so bit 0 covers 7..0 and bit 3 covers 31..24. `par_err` is high two clocks after an accepted word exactly when any byte of that word fails. This applies to data words and to the redundancy word.
- R4: The first accepted word after a word accepted with `in_last` high is treated as the redundancy word. It is forwarded with `out_is_llrc` high. `out_is_llrc` is low for all other words.
- R5: The expected redundancy value is N XOR (the XOR of all N data words of the burst). Here N counts the data words including the one marked last, zero-extended to 32 bits. Parity faults do not change this value.
- R6: `llrc_err` is high in the cycle the redundancy word is presented if the received word differs from the expected value, and low in every other cycle.
- R7: The word count and the accumulator restart after each redundancy word, so consecutive bursts are checked independently. A single-word burst has N = 1.
- R8: Synchronous active-low reset clears the word counter, the accumulator, the burst state, `out_valid`, `par_err` and `llrc_err`. A burst cut short by reset leaves no trace on the next one.
- R9: Cycles with `in_valid` low change nothing. `in_last` is ignored when `in_valid` is low, and it is also ignored on the redundancy word itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is present this cycle |
| in_last | input | 1 | The present word is the final data word of the burst |
| in_data | input | 32 | Received data word |
| in_par | input | 4 | Received byte parity bits |
| out_valid | output | 1 | Forwarded word present |
| out_data | output | 32 | Forwarded data word |
| out_par | output | 4 | Forwarded parity bits |
| out_is_llrc | output | 1 | Forwarded word is the burst redundancy word |
| par_err | output | 1 | Parity fault on the word forwarded one cycle earlier |
| llrc_err | output | 1 | Redundancy mismatch on the word forwarded now |

## Verification
On every cycle the embedded properties check four things. The one-cycle forwarding of data and parity must hold. The parity flag may appear only two cycles after an accepted word. A mismatch flag may appear only alongside a marked redundancy word. The counter and accumulator must hold still on idle cycles and restart after each redundancy word. The arithmetic needs the directed scenarios: count seeding, which is shown by an all-zero burst whose plain XOR would pass. Other scenarios cover which byte a parity bit guards, the independence of back-to-back bursts, the ignoring of `in_last` when idle, and recovery after a reset in the middle of a burst.

// File: rtl/burst_chk_pkg.sv
// Shared types for the burst integrity checker.
// Assumes: single clock domain, synchronous active-low reset.
package burst_chk_pkg;

    // Burst tracking state: collecting data words, or waiting for the redundancy word
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_AWAIT   = 1'b1
    } burst_state_e;

endpackage

// File: rtl/burst_parity_lanes.sv
// Per-byte odd parity checker with a two-stage flag pipeline.
// What: flags a received word whose bytes do not carry odd parity.
// Assumes: DATA_W is a multiple of LANE_W; one parity bit per lane,
//          bit i guarding lane i. Flag appears two cycles after the word.
module burst_parity_lanes #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_i,
    input  logic [DATA_W-1:0]          data_i,
    input  logic [DATA_W/LANE_W-1:0]   par_i,
    output logic                       par_err_o
);
    localparam int NLANE = DATA_W / LANE_W;

    logic [NLANE-1:0] lane_bad;
    logic             stage1_q;

    // One odd-parity test per lane: an even count of ones across lane and bit is a fault
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_bad[g] = ~(^{data_i[g*LANE_W +: LANE_W], par_i[g]});
    end

    // First stage: capture whether the accepted word had any failing lane
    always_ff @(posedge clk) begin
        if (!rst_n) stage1_q <= 1'b0;
        else        stage1_q <= valid_i & (|lane_bad);
    end

    // Second stage: present the flag one cycle after the forwarded word
    always_ff @(posedge clk) begin
        if (!rst_n) par_err_o <= 1'b0;
        else        par_err_o <= stage1_q;
    end

    // R3: the flag only appears two cycles after an accepted word
    p_flag_after_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> $past(valid_i, 2));

endmodule

// File: rtl/burst_llrc_track.sv
// Burst word counter and seeded longitudinal XOR accumulator.
// What: counts data words, XORs them, and at the redundancy word compares
//       the received value with count XOR accumulated data.
// Assumes: CNT_W <= DATA_W; the count wraps at 2**CNT_W words.
module burst_llrc_track
    import burst_chk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              is_llrc_o,
    output logic              llrc_err_o
);
    burst_state_e      state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] expect_w;
    logic              take_data;
    logic              take_check;

    assign take_data  = valid_i && (state_q == ST_COLLECT);
    assign take_check = valid_i && (state_q == ST_AWAIT);
    // The count acts as seed; XOR order is irrelevant so it is folded in at the end
    assign expect_w   = acc_q ^ DATA_W'(cnt_q);

    // Burst state: arm on the marked last word, return after the redundancy word
    always_ff @(posedge clk) begin
        if (!rst_n)                 state_q <= ST_COLLECT;
        else if (take_data && last_i) state_q <= ST_AWAIT;
        else if (take_check)        state_q <= ST_COLLECT;
    end

    // Word counter: one per data word, cleared once the burst is checked
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (take_check) cnt_q <= '0;
        else if (take_data)  cnt_q <= cnt_q + 1'b1;
    end

    // Accumulator: fold every data word in, cleared once the burst is checked
    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (take_check) acc_q <= '0;
        else if (take_data)  acc_q <= acc_q ^ data_i;
    end

    // Output flags aligned with the forwarded word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_llrc_o  <= 1'b0;
            llrc_err_o <= 1'b0;
        end else begin
            is_llrc_o  <= take_check;
            llrc_err_o <= take_check && (data_i != expect_w);
        end
    end

    // R4: a marked last data word arms the redundancy slot
    p_arm_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && state_q == ST_COLLECT && last_i) |=> (state_q == ST_AWAIT));

    // R7: counter and accumulator restart after the redundancy word
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && state_q == ST_AWAIT) |=> (cnt_q == '0 && acc_q == '0 && state_q == ST_COLLECT));

    // R9: idle cycles leave the burst state untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(cnt_q) && $stable(acc_q) && $stable(state_q)));

    // R6: mismatch can only be reported with the redundancy word
    p_err_with_llrc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        llrc_err_o |-> is_llrc_o);

endmodule

// File: rtl/burst_integrity_chk.sv
// Top: forwards received words unchanged and attaches parity and burst flags.
// What: one-cycle data/parity pass-through, parity flag one cycle behind it,
//       redundancy marker and mismatch flag aligned with the forwarded word.
// Assumes: no back-pressure; the sender never stalls the output.
module burst_integrity_chk #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DATA_W/LANE_W-1:0] in_par,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic [DATA_W/LANE_W-1:0] out_par,
    output logic                     out_is_llrc,
    output logic                     par_err,
    output logic                     llrc_err
);
    localparam int NLANE = DATA_W / LANE_W;

    // Pass-through register: data and parity unchanged, whatever their parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_par   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
                out_par  <= in_par;
            end
        end
    end

    burst_parity_lanes #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (in_valid),
        .data_i    (in_data),
        .par_i     (in_par),
        .par_err_o (par_err)
    );

    burst_llrc_track #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_llrc (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (in_valid),
        .last_i     (in_last),
        .data_i     (in_data),
        .is_llrc_o  (out_is_llrc),
        .llrc_err_o (llrc_err)
    );

    // R1, R2: forwarded word equals the accepted word, bad parity included
    p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data) && out_par == $past(in_par)));

    // R1: no forwarded word after an idle cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: the redundancy marker only rides on a forwarded word
    p_marker_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_llrc |-> out_valid);

    // Lane count sanity, checked once
    initial begin
        p_lane_fit_r3: assert (NLANE * LANE_W == DATA_W);
    end

endmodule

// File: tb/burst_integrity_chk_bench.sv
module burst_integrity_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_par = '0;
    logic        out_valid, out_is_llrc, par_err, llrc_err;
    logic [31:0] out_data;
    logic [3:0]  out_par;

    always #4 clk = ~clk;

    burst_integrity_chk u_burst_integrity_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_data(in_data), .in_par(in_par), .out_valid(out_valid),
        .out_data(out_data), .out_par(out_par), .out_is_llrc(out_is_llrc),
        .par_err(par_err), .llrc_err(llrc_err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state
    logic [15:0] m_cnt;
    logic [31:0] m_acc;
    bit          m_await;
    // Pending expectations: p1 shows next sample, p2 parity flag after that
    bit          p1_v, p1_llrc, p1_lerr, p1_perr;
    logic [31:0] p1_data;
    logic [3:0]  p1_par;
    string       p1_tag;
    bit          p2_perr;
    string       p2_tag;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] good_par(logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ~(^d[i*8 +: 8]);
        return p;
    endfunction

    // Compare current outputs with pending expectations, then shift them
    task automatic check_outputs();
        chk(p1_tag, "out_valid", 32'(out_valid), 32'(p1_v));
        if (p1_v) begin
            chk(p1_tag, "out_data", out_data, p1_data);
            chk(p1_tag, "out_par", 32'(out_par), 32'(p1_par));
            chk(p1_tag, "out_is_llrc", 32'(out_is_llrc), 32'(p1_llrc));
        end
        chk(p1_tag, "llrc_err", 32'(llrc_err), 32'(p1_lerr));
        chk(p2_tag, "par_err", 32'(par_err), 32'(p2_perr));
        p2_perr = p1_perr;
        p2_tag  = p1_tag;
    endtask

    // One cycle: check, drive new inputs, predict, advance to next falling edge
    task automatic step(bit v, bit last, logic [31:0] d, logic [3:0] p, string tag);
        check_outputs();
        in_valid = v; in_last = last; in_data = d; in_par = p;
        p1_v = v; p1_data = d; p1_par = p; p1_tag = tag;
        p1_llrc = 0; p1_lerr = 0;
        p1_perr = v && (p != good_par(d));
        if (v) begin
            if (m_await) begin
                p1_llrc = 1;
                p1_lerr = (d != (m_acc ^ {16'h0, m_cnt}));
                m_cnt = '0; m_acc = '0; m_await = 0;
            end else begin
                m_acc = m_acc ^ d;
                m_cnt = m_cnt + 1'b1;
                if (last) m_await = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 32'h0, 4'h0, tag);
    endtask

    task automatic do_reset(string tag);
        in_valid = 0; in_last = 0; in_data = '0; in_par = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cnt = '0; m_acc = '0; m_await = 0;
        p1_v = 0; p1_llrc = 0; p1_lerr = 0; p1_perr = 0; p2_perr = 0;
        p1_tag = tag; p2_tag = tag;
        chk(tag, "out_valid after reset", 32'(out_valid), 32'h0);
        chk(tag, "par_err after reset", 32'(par_err), 32'h0);
        chk(tag, "llrc_err after reset", 32'(llrc_err), 32'h0);
    endtask

    // R4 R5 R6: good burst, redundancy computed by the bench model
    task automatic t_good_burst();
        logic [31:0] w [3];
        logic [31:0] l;
        w[0] = 32'h1234_5678; w[1] = 32'hDEAD_BEEF; w[2] = 32'h0F0F_A5A5;
        l = w[0] ^ w[1] ^ w[2] ^ 32'd3;
        for (int i = 0; i < 3; i++) step(1, i == 2, w[i], good_par(w[i]), "R5");
        step(1, 0, l, good_par(l), "R6");
        idle(3, "R1");
    endtask

    // R5: all-zero burst must carry seed equal to count, plain XOR (0) mismatches
    task automatic t_seed();
        for (int i = 0; i < 3; i++) step(1, i == 2, 32'h0, good_par(32'h0), "R5");
        step(1, 0, 32'h0, good_par(32'h0), "R5");
        for (int i = 0; i < 3; i++) step(1, i == 2, 32'h0, good_par(32'h0), "R5");
        step(1, 0, 32'h3, good_par(32'h3), "R5");
        idle(3, "R5");
    endtask

    // R7: single-word bursts back to back
    task automatic t_single_bursts();
        step(1, 1, 32'hAAAA_0000, good_par(32'hAAAA_0000), "R7");
        step(1, 0, 32'hAAAA_0001, good_par(32'hAAAA_0001), "R7");
        step(1, 1, 32'h5555_1111, good_par(32'h5555_1111), "R7");
        step(1, 0, 32'hFFFF_FFFF, good_par(32'hFFFF_FFFF), "R6");
        idle(3, "R7");
    endtask

    // R2 R3: bad parity on byte 3 and byte 0, redundancy word with bad parity
    task automatic t_parity();
        logic [31:0] a, b, l;
        a = 32'h8000_0001; b = 32'h00FF_7E00;
        l = a ^ b ^ 32'd2;
        step(1, 0, a, good_par(a) ^ 4'b1000, "R3");
        step(1, 1, b, good_par(b) ^ 4'b0001, "R2");
        step(1, 0, l, good_par(l) ^ 4'b0110, "R3");
        step(1, 0, 32'h0101_0101, good_par(32'h0101_0101), "R3");
        step(1, 1, 32'h0101_0101, good_par(32'h0101_0101), "R3");
        step(1, 0, 32'h0101_0100, good_par(32'h0101_0100), "R3");
        idle(3, "R3");
    endtask

    // R9: gaps and stray in_last without valid, in_last on redundancy word
    task automatic t_gaps();
        logic [31:0] a, b, l;
        a = 32'hCAFE_0001; b = 32'h0BAD_F00D;
        l = a ^ b ^ 32'd2;
        step(1, 0, a, good_par(a), "R9");
        step(0, 1, 32'hFFFF_FFFF, 4'h0, "R9");
        step(0, 0, 32'h1357_9BDF, 4'hF, "R9");
        step(1, 1, b, good_par(b), "R9");
        step(0, 1, 32'h0, 4'h0, "R9");
        step(1, 1, l, good_par(l), "R9");
        step(1, 1, 32'h7, good_par(32'h7), "R9");
        step(1, 0, 32'h6, good_par(32'h6), "R9");
        idle(3, "R9");
    endtask

    // R8: reset in the middle of a burst leaves nothing behind
    task automatic t_reset_mid();
        step(1, 0, 32'h1111_1111, good_par(32'h1111_1111), "R8");
        step(1, 0, 32'h2222_2222, good_par(32'h2222_2222), "R8");
        do_reset("R8");
        step(1, 1, 32'h4444_0000, good_par(32'h4444_0000), "R8");
        step(1, 0, 32'h4444_0001, good_par(32'h4444_0001), "R8");
        idle(3, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R8");
        t_good_burst();
        t_seed();
        t_single_bursts();
        t_parity();
        t_gaps();
        t_reset_mid();
        check_outputs();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule